// File: doc/BRIEF.md
# Power Stage Fault Supervisor

This block gathers the protection inputs of a multi-channel switching power stage and turns them into one global high-impedance command for every half-bridge plus two active-low status lines: a shutdown line and a thermal warning line. Its inputs are one "supply good" comparator flag per monitored gate-drive or logic supply, an unsigned junction temperature code in degrees Celsius, an overload flag that a separate overload block already latches, and an active-low reset request from the system controller.

Undervoltage and thermal faults clear by themselves once the condition goes away. The temperature decisions use separate set and clear thresholds, so they have hysteresis. The supply flags come from an asynchronous analog domain. Each one passes through a two-flop synchronizer and a digital filter before it can act, which keeps short glitches from shutting the stage down. The overload flag is passed through unchanged: clearing it is the job of the overload block. While the reset request is low, all fault reporting is masked and the bridges are held off. The shutdown and warning lines together form a two-bit code that the controller reads.

Top module: `pstage_fault_sup`

## Requirements
- R1: While `rst_n` is low, `sd_n`=1, `warn_n`=1 and `hiz_all`=1. After `rst_n` is released with all supply flags low, `hiz_all` stays 1 and `sd_n` goes 0, so no power-up ordering of the supplies is needed.
- R2: The thermal warning becomes active only when `temp_c` is strictly greater than WARN_SET (default 125). `warn_n` then reads 0 two clock edges after the code is sampled. A code equal to WARN_SET gives no warning.
- R3: An active warning stays active while `temp_c` is greater than WARN_CLR (default 100). It clears when `temp_c` is at or below WARN_CLR.
- R4: A thermal error becomes active when `temp_c` is greater than ERR_SET (default 155). It gives `sd_n`=0, `warn_n`=0 and `hiz_all`=1 two edges later. It clears only when `temp_c` is at or below ERR_CLR (default 130).
- R5: A `sup_ok` bit held low gives `sd_n`=0 and `hiz_all`=1 exactly 7 clock edges after it is first sampled low. This counts 2 synchronizer flops, FILT_LEN=4 consecutive agreeing samples and the output register.
- R6: A `sup_ok` bit that is low for fewer than FILT_LEN consecutive cycles has no effect on any output.
- R7: Once every `sup_ok` bit has been high for FILT_LEN filtered samples, the outputs return to normal (`sd_n`=1, `hiz_all`=0) with the same 7-edge latency and without any reset.
- R8: `ovl_flag`=1 gives `sd_n`=0 and `hiz_all`=1 one edge later. The outputs follow the flag, with no latching inside this block.
- R9: While `reset_req_n` is low, `sd_n`=1, `warn_n`=1 and `hiz_all`=1 one edge later, regardless of any fault. On release, the faults still present show one edge later.
- R10: Status code {`sd_n`,`warn_n`}: 00 means a thermal error, or an overload/undervoltage together with a warning; 01 means overload or undervoltage without a warning; 10 means a warning only; 11 means normal. `hiz_all` is 0 only in the normal and warning-only states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the logic |
| reset_req_n | input | 1 | Active-low functional reset request; masks all fault reporting |
| sup_ok | input | N_SUP | Per-supply comparator flag, 1 = above the undervoltage threshold (asynchronous) |
| temp_c | input | TEMP_W | Junction temperature code in degrees Celsius, unsigned |
| ovl_flag | input | 1 | Latched overload indication from the overload block |
| sd_n | output | 1 | Active-low shutdown status |
| warn_n | output | 1 | Active-low overtemperature warning status |
| hiz_all | output | 1 | 1 = force all half-bridges to high impedance |

## Verification
The supply path and the thermal path both feed `sd_n`, and their latencies differ (7 edges against 2). A supply recovery can therefore be lined up with the release of a thermal error. The bench first holds a thermal error while a supply is also down. It then raises the supply flag and, five cycles later, drops the temperature, so the filter flip and the error clear both land on the sixth edge. The test passes if `sd_n` is still low one sample before that edge, and if `sd_n`, `warn_n` and `hiz_all` all return to normal together on the next sample, with no intermediate state seen.

// File: rtl/psfs_pkg.sv
package psfs_pkg;

  localparam int CODE_W = 16;

  typedef struct packed {
    logic sd_n;
    logic warn_n;
    logic hiz;
  } stat_t;

  // Next state of a hysteretic comparator: set strictly above set_lvl,
  // hold while strictly above clr_lvl.
  function automatic logic hyst_next(input logic act,
                                     input logic [CODE_W-1:0] code,
                                     input logic [CODE_W-1:0] set_lvl,
                                     input logic [CODE_W-1:0] clr_lvl);
    if (!act) return (code > set_lvl);
    return (code > clr_lvl);
  endfunction

  // Joint status code; mask_n low hides every fault.
  function automatic stat_t encode(input logic mask_n, input logic uv,
                                   input logic ovl, input logic err,
                                   input logic warn);
    stat_t s;
    if (!mask_n) begin
      s = '{sd_n: 1'b1, warn_n: 1'b1, hiz: 1'b1};
    end else begin
      s.sd_n   = ~(uv | ovl | err);
      s.warn_n = ~(warn | err);
      s.hiz    = uv | ovl | err;
    end
    return s;
  endfunction

endpackage

// File: rtl/psfs_sup_filter.sv
module psfs_sup_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_ok,
  output logic ok_q
);
  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic       s1, s2;
  logic [CW-1:0] cnt;
  logic       differs;
  logic       flip_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= raw_ok;
      s2 <= s1;
    end
  end

  assign differs = (s2 != ok_q);
  assign flip_ev = differs && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      ok_q <= 1'b0;
    end else if (flip_ev) begin
      cnt  <= '0;
      ok_q <= s2;
    end else if (differs) begin
      cnt  <= cnt + 1'b1;
    end else begin
      cnt  <= '0;
    end
  end

  // R6: the filtered state moves only after FILT_LEN agreeing samples
  assert_filter_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ok_q) |-> $past(cnt) == LAST);

  // R6: a sample equal to the held state restarts the count
  assert_count_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !differs |=> cnt == '0);

endmodule

// File: rtl/psfs_temp_hyst.sv
module psfs_temp_hyst
  import psfs_pkg::*;
#(
  parameter int TEMP_W  = 8,
  parameter int SET_LVL = 125,
  parameter int CLR_LVL = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp,
  output logic              act
);
  logic [CODE_W-1:0] code;
  logic              nxt;

  assign code = CODE_W'(temp);
  assign nxt  = hyst_next(act, code, CODE_W'(SET_LVL), CODE_W'(CLR_LVL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act <= 1'b0;
    else        act <= nxt;
  end

  // R2 / R4: crossing above the set level activates on the next edge
  assert_hyst_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && code > CODE_W'(SET_LVL)) |=> act);

  // R3 / R4: an active level holds while above the clear level
  assert_hyst_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act && code > CODE_W'(CLR_LVL)) |=> act);

  // R3: at or below the clear level the flag drops
  assert_hyst_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code <= CODE_W'(CLR_LVL)) |=> !act);

endmodule

// File: rtl/psfs_status_out.sv
module psfs_status_out
  import psfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mask_n,
  input  logic uv,
  input  logic ovl,
  input  logic err,
  input  logic warn,
  output logic sd_n,
  output logic warn_n,
  output logic hiz
);
  stat_t nxt;

  assign nxt = encode(mask_n, uv, ovl, err, warn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_n   <= 1'b1;
      warn_n <= 1'b1;
      hiz    <= 1'b1;
    end else begin
      sd_n   <= nxt.sd_n;
      warn_n <= nxt.warn_n;
      hiz    <= nxt.hiz;
    end
  end

  // R9: a reset request masks every status and holds the bridges off
  assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_n |=> (sd_n && warn_n && hiz));

  // R8: overload drives shutdown on the next edge
  assert_ovl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_n && ovl) |=> (!sd_n && hiz));

  // R5: undervoltage drives shutdown on the next edge
  assert_uv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_n && uv) |=> (!sd_n && hiz));

endmodule

// File: rtl/pstage_fault_sup.sv
module pstage_fault_sup #(
  parameter int N_SUP    = 3,
  parameter int TEMP_W   = 8,
  parameter int FILT_LEN = 4,
  parameter int WARN_SET = 125,
  parameter int WARN_CLR = 100,
  parameter int ERR_SET  = 155,
  parameter int ERR_CLR  = 130
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_req_n,
  input  logic [N_SUP-1:0]  sup_ok,
  input  logic [TEMP_W-1:0] temp_c,
  input  logic              ovl_flag,
  output logic              sd_n,
  output logic              warn_n,
  output logic              hiz_all
);
  logic [N_SUP-1:0] ok_filt;
  logic             uv_any;
  logic             warn_act;
  logic             err_act;

  for (genvar i = 0; i < N_SUP; i++) begin : g_sup
    psfs_sup_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_ok(sup_ok[i]),
      .ok_q  (ok_filt[i])
    );
  end

  assign uv_any = ~(&ok_filt);

  psfs_temp_hyst #(.TEMP_W(TEMP_W), .SET_LVL(WARN_SET), .CLR_LVL(WARN_CLR)) u_warn (
    .clk  (clk),
    .rst_n(rst_n),
    .temp (temp_c),
    .act  (warn_act)
  );

  psfs_temp_hyst #(.TEMP_W(TEMP_W), .SET_LVL(ERR_SET), .CLR_LVL(ERR_CLR)) u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .temp (temp_c),
    .act  (err_act)
  );

  psfs_status_out u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .mask_n(reset_req_n),
    .uv    (uv_any),
    .ovl   (ovl_flag),
    .err   (err_act),
    .warn  (warn_act),
    .sd_n  (sd_n),
    .warn_n(warn_n),
    .hiz   (hiz_all)
  );

  // R10: bridges are only driven when shutdown is not signalled
  assert_hiz_sd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hiz_all |-> sd_n);

  // R4: a thermal error never exists without the warning level
  assert_err_warn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_act |-> warn_act);

  // R1: while supplies are filtered low the bridges stay off
  assert_powerup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    uv_any |=> hiz_all);

endmodule

// File: tb/tb_pstage_fault_sup.sv
module tb_pstage_fault_sup;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reset_req_n;
  logic [2:0] sup_ok;
  logic [7:0] temp_c;
  logic       ovl_flag;
  logic       sd_n, warn_n, hiz_all;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pstage_fault_sup dut (
    .clk(clk), .rst_n(rst_n), .reset_req_n(reset_req_n), .sup_ok(sup_ok),
    .temp_c(temp_c), .ovl_flag(ovl_flag), .sd_n(sd_n), .warn_n(warn_n),
    .hiz_all(hiz_all)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect3(input string req, input logic e_sd, input logic e_w,
                         input logic e_h);
    n_chk++;
    if ({sd_n, warn_n, hiz_all} !== {e_sd, e_w, e_h}) begin
      n_fail++;
      $display("FAIL %s: sd_n/warn_n/hiz_all = %b%b%b, expected %b%b%b",
               req, sd_n, warn_n, hiz_all, e_sd, e_w, e_h);
    end
  endtask

  task automatic t_reset_powerup;
    rst_n = 1'b0; reset_req_n = 1'b1; sup_ok = 3'b000; temp_c = 8'd25;
    ovl_flag = 1'b0;
    tick(3);
    expect3("R1 in reset", 1, 1, 1);
    rst_n = 1'b1;
    tick(10);
    expect3("R1 supplies low after reset", 0, 1, 1);
    sup_ok = 3'b111;
    tick(6);
    expect3("R7 power-up not before 7 edges", 0, 1, 1);
    tick(1);
    expect3("R7 power-up after 7 edges", 1, 1, 0);
  endtask

  task automatic t_warning;
    temp_c = 8'd125; tick(3);
    expect3("R2 equal to set level", 1, 1, 0);
    temp_c = 8'd126; tick(1);
    expect3("R2 one edge only", 1, 1, 0);
    tick(1);
    expect3("R2 warning set", 1, 0, 0);
    temp_c = 8'd101; tick(4);
    expect3("R3 hold above clear", 1, 0, 0);
    temp_c = 8'd100; tick(2);
    expect3("R3 clear at level", 1, 1, 0);
  endtask

  task automatic t_error;
    temp_c = 8'd155; tick(3);
    expect3("R4 equal to error level", 1, 0, 0);
    temp_c = 8'd156; tick(2);
    expect3("R4 error set", 0, 0, 1);
    temp_c = 8'd131; tick(3);
    expect3("R4 error hold", 0, 0, 1);
    temp_c = 8'd130; tick(2);
    expect3("R4 error clear, warning kept", 1, 0, 0);
    temp_c = 8'd20; tick(2);
    expect3("R3 back to normal", 1, 1, 0);
  endtask

  task automatic t_undervoltage;
    sup_ok[1] = 1'b0; tick(6);
    expect3("R5 not before 7 edges", 1, 1, 0);
    tick(1);
    expect3("R5 undervoltage", 0, 1, 1);
    sup_ok[1] = 1'b1; tick(6);
    expect3("R7 recovery not early", 0, 1, 1);
    tick(1);
    expect3("R7 automatic recovery", 1, 1, 0);
  endtask

  task automatic t_glitch;
    int bad = 0;
    sup_ok[0] = 1'b0; tick(3);
    sup_ok[0] = 1'b1;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      if ({sd_n, warn_n, hiz_all} !== 3'b110) bad++;
    end
    n_chk++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL R6 glitch: %0d bad samples, expected 0 (last %b%b%b vs 110)",
               bad, sd_n, warn_n, hiz_all);
    end
  endtask

  task automatic t_warn_plus_uv;
    temp_c = 8'd140; tick(2);
    expect3("R10 warning only", 1, 0, 0);
    sup_ok[2] = 1'b0; tick(7);
    expect3("R10 warning with undervoltage", 0, 0, 1);
    sup_ok[2] = 1'b1; temp_c = 8'd20; tick(8);
    expect3("R10 normal", 1, 1, 0);
  endtask

  task automatic t_overload;
    ovl_flag = 1'b1; tick(1);
    expect3("R8 overload", 0, 1, 1);
    tick(3);
    expect3("R8 overload held", 0, 1, 1);
    ovl_flag = 1'b0; tick(1);
    expect3("R8 follows flag", 1, 1, 0);
  endtask

  task automatic t_mask;
    int bad = 0;
    ovl_flag = 1'b1; temp_c = 8'd200; sup_ok[0] = 1'b0; reset_req_n = 1'b0;
    tick(1);
    expect3("R9 masked", 1, 1, 1);
    for (int i = 0; i < 10; i++) begin
      tick(1);
      if ({sd_n, warn_n, hiz_all} !== 3'b111) bad++;
    end
    n_chk++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL R9 mask held: %0d bad samples, expected 0", bad);
    end
    reset_req_n = 1'b1; tick(1);
    expect3("R9 faults shown on release", 0, 0, 1);
    ovl_flag = 1'b0; temp_c = 8'd20; sup_ok[0] = 1'b1; tick(8);
    expect3("R9 normal after faults clear", 1, 1, 0);
  endtask

  // Supply recovery and thermal-error release on the same edge
  task automatic t_same_cycle;
    temp_c = 8'd200; sup_ok[2] = 1'b0; tick(8);
    expect3("R4 error with undervoltage", 0, 0, 1);
    sup_ok[2] = 1'b1; tick(5);
    temp_c = 8'd20; tick(1);
    expect3("R7 same-cycle not early", 0, 0, 1);
    tick(1);
    expect3("R7 same-cycle joint release", 1, 1, 0);
  endtask

  initial begin
    rst_n = 1'b0; reset_req_n = 1'b1; sup_ok = '0; temp_c = '0; ovl_flag = 1'b0;
    t_reset_powerup();
    t_warning();
    t_error();
    t_undervoltage();
    t_glitch();
    t_warn_plus_uv();
    t_overload();
    t_mask();
    t_same_cycle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule